// File: doc/BRIEF.md
# Asynchronous SRAM Byte-Lane Controller

This block sits between a simple clocked request port and an asynchronous static RAM of 128K words by 16 bits. A host offers one access at a time through a valid/ready handshake: a write flag, a word address, write data and a per-lane byte mask. The controller turns each accepted request into a timed pin sequence on the memory side. The memory side has the address, active-low chip, output and write enables, one active-low strobe per byte lane, and a bidirectional data bus that is split into out, out-enable and in.

Every memory timing minimum is a parameter in nanoseconds. Each one is rounded up to whole clock cycles at the configured clock period, and never to fewer than one cycle. A read holds chip and output enable low for the access count and then captures the bus. A write first raises output enable so that the memory's drivers float. It then pulses write enable while the controller drives the bus, and holds the data for one more cycle after the pulse ends. Between any two accesses there is at least one cycle with chip enable high, so a write that follows a read never meets the memory still driving.

Top module: `sram_lane_ctrl`

## Requirements
- R1: When reset is released, `mem_ce_n`, `mem_oe_n` and `mem_we_n` are 1, `mem_be_n` is 2'b11, `dq_oe` and `rd_valid` are 0, and `req_ready` is 1.
- R2: An accepted read drives `req_addr` onto `mem_addr` with `mem_ce_n`=0, `mem_oe_n`=0 and `mem_we_n`=1 for the access count. During that time `mem_be_n[i]` is the inverse of `req_mask[i]`, where lane 0 is bits 7:0 and lane 1 is bits 15:8.
- R3: After the access count of a read, `rd_valid` is 1 for exactly one cycle. In that cycle `rd_data` holds the bus value on each lane whose mask bit is 1, and zero on each lane whose mask bit is 0.
- R4: In a write, `mem_oe_n` is 1 and `mem_ce_n` is 0 for at least one cycle before `mem_we_n` falls. `mem_we_n` is never low while `mem_oe_n` is low.
- R5: A write changes only the lanes whose mask bit is 1. The other lane keeps its earlier contents, which a later full-mask read shows.
- R6: `dq_oe` is 1 only while `mem_oe_n` is 1 and `mem_ce_n` is 0. It rises in the same cycle that `mem_we_n` falls, and falls in the cycle after `mem_we_n` rises.
- R7: While `mem_ce_n` stays low, `mem_addr` and `mem_be_n` do not change. While `dq_oe` stays high, `dq_out` does not change, and it equals the request's write data.
- R8: `req_ready` is 1 only while the memory is idle, with `mem_ce_n`=1. Every access, including a write that directly follows a read, is preceded by at least one cycle with `mem_ce_n` high.
- R9: The controller and the memory never drive the data bus in the same cycle.
- R10: A request with mask 2'b00 runs its cycle with both strobes high. Such a write changes no memory word, and such a read returns zero.
- R11: A request offered while `req_ready` is 0 is not taken. It has no effect on the memory unless it is still offered when `req_ready` returns to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | Host offers a request |
| req_ready | output | 1 | Controller can take a request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 17 | Word address |
| req_wdata | input | 16 | Write data |
| req_mask | input | 2 | Lane select; bit 0 = bits 7:0, bit 1 = bits 15:8 |
| rd_valid | output | 1 | One-cycle pulse with read data |
| rd_data | output | 16 | Read data, unselected lanes zero |
| mem_addr | output | 17 | Memory address |
| mem_ce_n | output | 1 | Chip enable, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_be_n | output | 2 | Lane strobes, active low; bit 0 = lower lane |
| dq_out | output | 16 | Data the controller drives onto the bus |
| dq_oe | output | 1 | Controller drives the bus |
| dq_in | input | 16 | Data seen on the bus |

## Verification
The properties assume that the host changes its request only through the handshake, and that `dq_in` settles within the configured access time once chip and output enable are low. The stimulus drives every request at the falling clock edge and holds it until the rising edge that accepts it. The bench memory model answers combinationally on the lanes that the truth table enables, so captured read data is stable at the capture edge. The model also counts any cycle in which both sides drive the bus and any write strobe without driven data, and the bench checks both counts.

// File: rtl/sram_lane_pkg.sv
// Shared types and helpers for the SRAM byte-lane controller.
// Assumes timing minimums are given in whole nanoseconds.
package sram_lane_pkg;

    typedef enum logic [2:0] {
        S_IDLE     = 3'd0,
        S_RD       = 3'd1,
        S_WR_LEAD  = 3'd2,
        S_WR_PULSE = 3'd3,
        S_WR_HOLD  = 3'd4
    } seq_state_t;

    // Round a nanosecond minimum up to clock cycles, never below one.
    function automatic int unsigned ns_to_cyc(input int unsigned ns, input int unsigned per);
        int unsigned r;
        r = (ns + per - 1) / per;
        if (r < 1) r = 1;
        return r;
    endfunction

    function automatic int unsigned max3(input int unsigned a, input int unsigned b, input int unsigned c);
        int unsigned m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/sram_lane_seq.sv
// Phase sequencer: walks idle -> read, or idle -> lead -> pulse -> hold.
// Memory control pins are registered from the next state so that they
// change only at clock edges and carry no decode glitches.
// Assumes each cycle count parameter is at least one.
module sram_lane_seq
    import sram_lane_pkg::*;
#(
    parameter int unsigned ACC_CYC   = 1,
    parameter int unsigned LEAD_CYC  = 1,
    parameter int unsigned PULSE_CYC = 1,
    parameter int unsigned CNT_W     = 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic req_valid,
    input  logic req_write,
    output logic req_ready,
    output logic accept,
    output logic rd_capture,
    output logic nxt_idle,
    output logic ce_n,
    output logic oe_n,
    output logic we_n,
    output logic drive
);

    localparam logic [CNT_W-1:0] ACC_LD   = CNT_W'(ACC_CYC - 1);
    localparam logic [CNT_W-1:0] LEAD_LD  = CNT_W'(LEAD_CYC - 1);
    localparam logic [CNT_W-1:0] PULSE_LD = CNT_W'(PULSE_CYC - 1);

    seq_state_t       st, nxt_st;
    logic [CNT_W-1:0] cnt, nxt_cnt;
    logic             last;

    assign req_ready  = (st == S_IDLE);
    assign accept     = req_valid && req_ready;
    assign last       = (cnt == '0);
    assign rd_capture = (st == S_RD) && last;
    assign nxt_idle   = (nxt_st == S_IDLE);

    // Next phase and phase counter.
    always_comb begin
        nxt_st  = st;
        nxt_cnt = cnt;
        unique case (st)
            S_IDLE: if (accept) begin
                nxt_st  = req_write ? S_WR_LEAD : S_RD;
                nxt_cnt = req_write ? LEAD_LD : ACC_LD;
            end
            S_RD: if (last) nxt_st = S_IDLE;
                  else      nxt_cnt = cnt - 1'b1;
            S_WR_LEAD: if (last) begin
                nxt_st  = S_WR_PULSE;
                nxt_cnt = PULSE_LD;
            end else nxt_cnt = cnt - 1'b1;
            S_WR_PULSE: if (last) nxt_st = S_WR_HOLD;
                        else      nxt_cnt = cnt - 1'b1;
            S_WR_HOLD: nxt_st = S_IDLE;
            default:   nxt_st = S_IDLE;
        endcase
    end

    // State, counter and registered pin drive.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st    <= S_IDLE;
            cnt   <= '0;
            ce_n  <= 1'b1;
            oe_n  <= 1'b1;
            we_n  <= 1'b1;
            drive <= 1'b0;
        end else begin
            st    <= nxt_st;
            cnt   <= nxt_cnt;
            ce_n  <= (nxt_st == S_IDLE);
            oe_n  <= (nxt_st != S_RD);
            we_n  <= (nxt_st != S_WR_PULSE);
            drive <= (nxt_st == S_WR_PULSE) || (nxt_st == S_WR_HOLD);
        end
    end

endmodule

// File: rtl/sram_lane_dp.sv
// Datapath: holds the accepted address, write data and lane mask for the
// whole access, drives the lane strobes, and captures masked read data.
// Assumes DATA_W is a whole number of 8-bit lanes.
module sram_lane_dp #(
    parameter int unsigned ADDR_W = 17,
    parameter int unsigned DATA_W = 16,
    parameter int unsigned LANES  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept,
    input  logic              nxt_idle,
    input  logic              rd_capture,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [LANES-1:0]  req_mask,
    input  logic [DATA_W-1:0] dq_in,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [LANES-1:0]  mem_be_n,
    output logic [DATA_W-1:0] dq_out,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data
);

    localparam int unsigned LANE_W = DATA_W / LANES;

    logic [LANES-1:0] mask_q;

    // Request hold registers and strobe drive.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem_addr <= '0;
            dq_out   <= '0;
            mask_q   <= '0;
            mem_be_n <= '1;
        end else if (accept) begin
            mem_addr <= req_addr;
            dq_out   <= req_wdata;
            mask_q   <= req_mask;
            mem_be_n <= ~req_mask;
        end else if (nxt_idle) begin
            mem_be_n <= '1;
        end
    end

    // Read-valid pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) rd_valid <= 1'b0;
        else        rd_valid <= rd_capture;
    end

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        // Per-lane capture; an unselected lane returns zero.
        always_ff @(posedge clk) begin
            if (!rst_n)
                rd_data[g*LANE_W +: LANE_W] <= '0;
            else if (rd_capture)
                rd_data[g*LANE_W +: LANE_W] <= mask_q[g] ? dq_in[g*LANE_W +: LANE_W] : '0;
        end
    end

endmodule

// File: rtl/sram_lane_ctrl.sv
// Top of the SRAM byte-lane controller. Derives the cycle counts from the
// nanosecond minimums and clock period, and joins sequencer and datapath.
// Assumes one outstanding request and a memory that answers within T_AA_NS.
module sram_lane_ctrl
    import sram_lane_pkg::*;
#(
    parameter int unsigned ADDR_W        = 17,
    parameter int unsigned DATA_W        = 16,
    parameter int unsigned CLK_PERIOD_NS = 10,
    parameter int unsigned T_AA_NS       = 10,
    parameter int unsigned T_OE_LEAD_NS  = 4,
    parameter int unsigned T_PWE_NS      = 8,
    parameter int unsigned T_SD_NS       = 6,
    parameter int unsigned T_AW_NS       = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  req_valid,
    output logic                  req_ready,
    input  logic                  req_write,
    input  logic [ADDR_W-1:0]     req_addr,
    input  logic [DATA_W-1:0]     req_wdata,
    input  logic [DATA_W/8-1:0]   req_mask,
    output logic                  rd_valid,
    output logic [DATA_W-1:0]     rd_data,
    output logic [ADDR_W-1:0]     mem_addr,
    output logic                  mem_ce_n,
    output logic                  mem_oe_n,
    output logic                  mem_we_n,
    output logic [DATA_W/8-1:0]   mem_be_n,
    output logic [DATA_W-1:0]     dq_out,
    output logic                  dq_oe,
    input  logic [DATA_W-1:0]     dq_in
);

    localparam int unsigned LANES     = DATA_W / 8;
    localparam int unsigned ACC_CYC   = ns_to_cyc(T_AA_NS, CLK_PERIOD_NS);
    localparam int unsigned LEAD_CYC  = ns_to_cyc(T_OE_LEAD_NS, CLK_PERIOD_NS);
    localparam int unsigned PULSE_CYC = max3(ns_to_cyc(T_PWE_NS, CLK_PERIOD_NS),
                                             ns_to_cyc(T_SD_NS, CLK_PERIOD_NS),
                                             ns_to_cyc(T_AW_NS, CLK_PERIOD_NS));
    localparam int unsigned MAX_CYC   = max3(ACC_CYC, LEAD_CYC, PULSE_CYC);
    localparam int unsigned CNT_W     = (MAX_CYC > 1) ? $clog2(MAX_CYC) : 1;

    logic accept, rd_capture, nxt_idle;

    sram_lane_seq #(
        .ACC_CYC   (ACC_CYC),
        .LEAD_CYC  (LEAD_CYC),
        .PULSE_CYC (PULSE_CYC),
        .CNT_W     (CNT_W)
    ) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .req_write  (req_write),
        .req_ready  (req_ready),
        .accept     (accept),
        .rd_capture (rd_capture),
        .nxt_idle   (nxt_idle),
        .ce_n       (mem_ce_n),
        .oe_n       (mem_oe_n),
        .we_n       (mem_we_n),
        .drive      (dq_oe)
    );

    sram_lane_dp #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .LANES  (LANES)
    ) u_dp (
        .clk        (clk),
        .rst_n      (rst_n),
        .accept     (accept),
        .nxt_idle   (nxt_idle),
        .rd_capture (rd_capture),
        .req_addr   (req_addr),
        .req_wdata  (req_wdata),
        .req_mask   (req_mask),
        .dq_in      (dq_in),
        .mem_addr   (mem_addr),
        .mem_be_n   (mem_be_n),
        .dq_out     (dq_out),
        .rd_valid   (rd_valid),
        .rd_data    (rd_data)
    );

endmodule

// File: rtl/sram_lane_ctrl_chk.sv
// Protocol checker for the SRAM byte-lane controller, bound to the top.
// Observes ports only.
module sram_lane_ctrl_chk #(
    parameter int unsigned ADDR_W = 17,
    parameter int unsigned DATA_W = 16
) (
    input logic                clk,
    input logic                rst_n,
    input logic                req_valid,
    input logic                req_ready,
    input logic                rd_valid,
    input logic [ADDR_W-1:0]   mem_addr,
    input logic                mem_ce_n,
    input logic                mem_oe_n,
    input logic                mem_we_n,
    input logic [DATA_W/8-1:0] mem_be_n,
    input logic [DATA_W-1:0]   dq_out,
    input logic                dq_oe
);

    // R4
    we_lead_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mem_we_n) |-> mem_oe_n && $past(mem_oe_n) && $past(!mem_ce_n));
    // R4
    we_oe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |-> mem_oe_n && !mem_ce_n);
    // R6
    drv_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dq_oe |-> mem_oe_n && !mem_ce_n);
    // R6
    drv_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dq_oe) |-> $fell(mem_we_n));
    // R6
    drv_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_we_n) |-> dq_oe ##1 !dq_oe);
    // R7
    addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_ce_n && $past(!mem_ce_n)) |-> $stable(mem_addr) && $stable(mem_be_n));
    // R7
    data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dq_oe && $past(dq_oe)) |-> $stable(dq_out));
    // R8
    ready_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> mem_ce_n && mem_oe_n && mem_we_n && !dq_oe);
    // R8
    start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mem_ce_n) |-> $past(req_ready && req_valid));
    // R3
    rv_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |=> !rd_valid);
    // R3
    rv_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> $past(!mem_oe_n && mem_we_n));

endmodule

bind sram_lane_ctrl sram_lane_ctrl_chk #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .rd_valid  (rd_valid),
    .mem_addr  (mem_addr),
    .mem_ce_n  (mem_ce_n),
    .mem_oe_n  (mem_oe_n),
    .mem_we_n  (mem_we_n),
    .mem_be_n  (mem_be_n),
    .dq_out    (dq_out),
    .dq_oe     (dq_oe)
);

// File: tb/sram_lane_ctrl_test.sv
// Self-checking bench with a behavioural byte-lane memory model.
module sram_lane_ctrl_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_write = 1'b0;
    logic [16:0] req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic [1:0]  req_mask = '0;
    logic        rd_valid;
    logic [15:0] rd_data;
    logic [16:0] mem_addr;
    logic        mem_ce_n, mem_oe_n, mem_we_n, dq_oe;
    logic [1:0]  mem_be_n;
    logic [15:0] dq_out, dq_in;

    int checks = 0;
    int bad = 0;
    int clash = 0;
    int undriven = 0;
    bit done = 0;

    always #10 clk = ~clk;

    sram_lane_ctrl #(.CLK_PERIOD_NS(20)) uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
        .req_mask(req_mask), .rd_valid(rd_valid), .rd_data(rd_data),
        .mem_addr(mem_addr), .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n),
        .mem_we_n(mem_we_n), .mem_be_n(mem_be_n), .dq_out(dq_out),
        .dq_oe(dq_oe), .dq_in(dq_in)
    );

    // Memory model: 1024 words indexed by the low address bits.
    logic [15:0] mem [1024];
    logic [9:0]  idx;
    logic        m_lo, m_hi;
    assign idx  = mem_addr[9:0];
    assign m_lo = !mem_ce_n && !mem_oe_n && mem_we_n && !mem_be_n[0];
    assign m_hi = !mem_ce_n && !mem_oe_n && mem_we_n && !mem_be_n[1];
    assign dq_in[7:0]  = m_lo ? mem[idx][7:0]  : (dq_oe ? dq_out[7:0]  : 8'h00);
    assign dq_in[15:8] = m_hi ? mem[idx][15:8] : (dq_oe ? dq_out[15:8] : 8'h00);

    initial for (int i = 0; i < 1024; i++) mem[i] = 16'h0000;

    // Model write strobe and bus-clash monitor, mid-cycle.
    always @(negedge clk) begin
        if (dq_oe && (m_lo || m_hi)) clash++;
        if (!mem_ce_n && !mem_we_n) begin
            if (!mem_be_n[0]) begin
                if (!dq_oe) undriven++; else mem[idx][7:0] <= dq_out[7:0];
            end
            if (!mem_be_n[1]) begin
                if (!dq_oe) undriven++; else mem[idx][15:8] <= dq_out[15:8];
            end
        end
    end

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    // Present a request at a falling edge, return at the falling edge after acceptance.
    task automatic issue(input bit wr, input logic [16:0] a, input logic [15:0] d, input logic [1:0] m);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d; req_mask = m;
        while (!req_ready) @(negedge clk);
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic do_write(input logic [16:0] a, input logic [15:0] d, input logic [1:0] m);
        issue(1'b1, a, d, m);
        // R4 lead phase: chip enabled, outputs off, bus not driven
        check(!mem_ce_n && mem_oe_n && mem_we_n && !dq_oe && !req_ready, "R4 lead",
              {mem_ce_n, mem_oe_n, mem_we_n, dq_oe, req_ready}, 5'b01100);
        check(mem_be_n == ~m && mem_addr == a, "R7 wr addr/strobe", {mem_be_n, mem_addr}, {~m, a});
        @(negedge clk);
        // R6 pulse phase: write enable low and bus driven with the data
        check(!mem_we_n && dq_oe && mem_oe_n, "R6 pulse", {mem_we_n, dq_oe, mem_oe_n}, 3'b011);
        check(dq_out == d, "R7 wr data", dq_out, d);
        @(negedge clk);
        check(mem_we_n && dq_oe && !mem_ce_n, "R6 hold", {mem_we_n, dq_oe, mem_ce_n}, 3'b110);
        @(negedge clk);
        // R8 back to idle
        check(mem_ce_n && !dq_oe && req_ready && mem_be_n == 2'b11, "R8 wr idle",
              {mem_ce_n, dq_oe, req_ready, mem_be_n}, 5'b10111);
    endtask

    task automatic do_read(input logic [16:0] a, input logic [1:0] m, input logic [15:0] exp);
        issue(1'b0, a, 16'h0000, m);
        // R2 read pins
        check(!mem_ce_n && !mem_oe_n && mem_we_n && !dq_oe, "R2 rd pins",
              {mem_ce_n, mem_oe_n, mem_we_n, dq_oe}, 4'b0010);
        check(mem_be_n == ~m && mem_addr == a, "R2 rd addr/strobe", {mem_be_n, mem_addr}, {~m, a});
        @(negedge clk);
        // R3 data returned, R8 idle again
        check(rd_valid && rd_data == exp, "R3 rd data", {rd_valid, rd_data}, {1'b1, exp});
        check(mem_ce_n && req_ready, "R8 rd idle", {mem_ce_n, req_ready}, 2'b11);
    endtask

    // {write, addr, data, mask, expected read}
    localparam int NV = 11;
    localparam logic [51:0] VEC [NV] = '{
        {1'b1, 17'h00010, 16'hFFFF, 2'b11, 16'h0000},
        {1'b1, 17'h00010, 16'h1234, 2'b01, 16'h0000},  // R5 lower lane only
        {1'b0, 17'h00010, 16'h0000, 2'b11, 16'hFF34},  // R5
        {1'b1, 17'h1FFFF, 16'hBEEF, 2'b11, 16'h0000},
        {1'b0, 17'h1FFFF, 16'h0000, 2'b10, 16'hBE00},  // R3 unselected lane zero
        {1'b1, 17'h1FFFF, 16'h0000, 2'b10, 16'h0000},  // R5 upper lane only
        {1'b0, 17'h1FFFF, 16'h0000, 2'b11, 16'h00EF},  // R5
        {1'b0, 17'h00010, 16'h0000, 2'b01, 16'h0034},  // R3
        {1'b1, 17'h00155, 16'hAAAA, 2'b00, 16'h0000},  // R10 no lane written
        {1'b0, 17'h00155, 16'h0000, 2'b11, 16'h0000},  // R10
        {1'b0, 17'h00155, 16'h0000, 2'b00, 16'h0000}   // R10 empty read
    };

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(mem_ce_n && mem_oe_n && mem_we_n && mem_be_n == 2'b11 && !dq_oe && !rd_valid && req_ready,
              "R1 reset", {mem_ce_n, mem_oe_n, mem_we_n, mem_be_n, dq_oe, rd_valid, req_ready},
              8'b11111001);

        for (int i = 0; i < NV; i++) begin
            if (VEC[i][51]) do_write(VEC[i][50:34], VEC[i][33:18], VEC[i][17:16]);
            else            do_read (VEC[i][50:34], VEC[i][17:16], VEC[i][15:0]);
        end

        // R8 read directly followed by write: gap of one idle cycle
        do_read(17'h00010, 2'b11, 16'hFF34);
        do_write(17'h00010, 16'h5A5A, 2'b11);
        do_read(17'h00010, 2'b11, 16'h5A5A);

        // R11 request offered while busy is not taken
        req_valid = 1'b1; req_write = 1'b1; req_addr = 17'h00040; req_wdata = 16'hC3C3; req_mask = 2'b11;
        @(posedge clk);
        @(negedge clk);
        req_addr = 17'h00200; req_wdata = 16'h5555;
        @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        check(!req_ready, "R11 still busy", req_ready, 1'b0);
        @(negedge clk);
        check(req_ready && mem_ce_n, "R11 idle", {req_ready, mem_ce_n}, 2'b11);
        @(negedge clk);
        do_read(17'h00200, 2'b11, 16'h0000);   // R11 busy offer left no trace
        do_read(17'h00040, 2'b11, 16'hC3C3);   // R11 accepted one written

        // R9 bus contention and undriven strobes
        check(clash == 0, "R9 clash", clash, 0);
        check(undriven == 0, "R9 undriven write", undriven, 0);

        done = 1;
        $display("  test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end

    // Watchdog.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            bad++;
            $display("FAIL watchdog act=%0d exp=%0d", 1, 0);
            $display("  test done: total=%0d bad=%0d", checks, bad);
            $finish;
        end
    end

endmodule